// File: doc/BRIEF.md
# Reversible-Gate Programmable Logic Array

This block is a purely combinational programmable logic array whose every logic operation is made by an instantiated reversible gate. It uses only two primitives: a 2-in/2-out controlled-NOT and a 3-in/3-out controlled-swap. The AND plane decodes the select inputs into a full set of minterms. The OR plane then merges the minterms that the program word enables into one function output.

No gate output drives more than one gate input. Wherever a signal is needed twice, a controlled-NOT with a constant 0 makes the copy. Inverted literals come from a controlled-NOT with a constant 1. AND and OR are controlled-swap gates with a constant third input.

Every unused gate output leaves the block on one garbage bus. The number of constant inputs the structure consumes is given on an output port. This lets a user weigh the cost of reversibility. The inputs and constants on one side must balance the function output and garbage on the other.

Top module: `rpla_top`

## Requirements
- R1: The controlled-NOT primitive maps (a, b) to p = a, q = a XOR b. Over its 4 input patterns the 2-bit outputs {p, q} are all distinct.
- R2: The controlled-swap primitive maps (a, b, c) to p = a, q = (~a & b) | (a & c), r = (a & b) | (~a & c). It keeps the count of ones from input to output. Over its 8 input patterns the outputs {p, q, r} are all distinct.
- R3: For every select value `sel` and program word `prog`, output `f` equals `prog[sel]`. Here `sel` is read as an unsigned index and bit i of `prog` enables minterm i.
- R4: With `prog` all zeros, `f` is 0 for every `sel`. With `prog` all ones, `f` is 1 for every `sel`.
- R5: With 3 select inputs, the garbage bus is 74 bits wide. With 2 select inputs, it is 26 bits wide.
- R6: `const_used` reports 64 with 3 select inputs and 21 with 2. In both cases, `const_used` plus the select width plus the program width equals the garbage width plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | N_IN | Function inputs; minterm index, bit 0 least significant |
| prog | input | 2**N_IN | Program word; bit i enables minterm i |
| f | output | 1 | Programmed function output |
| garbage | output | garb_count(N_IN) | All unused reversible gate outputs |
| const_used | output | 16 | Count of constant inputs tied inside the structure |

## Verification
The bench builds the array twice: once with the default N_IN = 3 and once with N_IN = 2. The 3-input build is swept over all 256 program words at every one of its 8 select values, with random program and select pairs mixed in. The 2-input build is swept over all 16 programs. Having two sizes shows that the garbage width and the constant count scale with the parameter by the expected formulas, not only at the default. Each primitive is also driven on its own through its complete input space to confirm its mapping and that it is one-to-one.

// File: rtl/rpla_pkg.sv
// Package: sizing helpers for the reversible logic array.
// Assumes N_IN >= 2 so that every minterm needs at least one AND gate.
package rpla_pkg;

    // Number of minterms for n inputs.
    function automatic int n_term(input int n);
        return 1 << n;
    endfunction

    // AND plane garbage: one per inverter, two per AND gate.
    function automatic int and_garb(input int n);
        return n * (n_term(n) / 2) + 2 * n_term(n) * (n - 1);
    endfunction

    // OR plane garbage: two per gating gate, two per OR gate.
    function automatic int or_garb(input int n);
        return 2 * n_term(n) + 2 * (n_term(n) - 1);
    endfunction

    // Total garbage outputs of the array.
    function automatic int garb_count(input int n);
        return and_garb(n) + or_garb(n);
    endfunction

    // AND plane constants: copy gates, inverters, AND gates.
    function automatic int and_const(input int n);
        return n * (n_term(n) - 1) + n * (n_term(n) / 2) + n_term(n) * (n - 1);
    endfunction

    // OR plane constants: gating gates plus OR gates.
    function automatic int or_const(input int n);
        return 2 * n_term(n) - 1;
    endfunction

    // Rank of minterm i among minterms whose bit k is clear (bit k removed).
    function automatic int drop_bit(input int i, input int k);
        return ((i >> (k + 1)) << k) | (i & ((1 << k) - 1));
    endfunction

endpackage

// File: rtl/rev_cnot.sv
// Controlled-NOT: 2-in/2-out reversible gate.
// p passes the control through; q is control XOR target.
// Assumes each output feeds at most one consumer.
module rev_cnot (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);

    // Gate mapping.
    assign p = a;
    assign q = a ^ b;

    // Guard: control passes and target is recoverable.
    always_comb begin
        a_r1_control_passes: assert (p == a);
        a_r1_target_recovers: assert ((p ^ q) == b);
    end

endmodule

// File: rtl/rev_cswap.sv
// Controlled-swap: 3-in/3-out conservative reversible gate.
// When a is 0, b and c pass straight; when a is 1 they trade places.
// Assumes each output feeds at most one consumer.
module rev_cswap (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);

    // Conditional exchange of b and c under control a.
    always_comb begin
        p = a;
        q = a ? c : b;
        r = a ? b : c;
    end

    // Guard: ones are conserved and control is untouched.
    always_comb begin
        a_r2_ones_kept: assert ($countones({p, q, r}) == $countones({a, b, c}));
        a_r2_control_kept: assert (p == a);
    end

endmodule

// File: rtl/rpla_and_plane.sv
// AND plane: decodes N_IN select bits into 2**N_IN one-hot minterms.
// Each select bit is copied by a controlled-NOT chain (constant 0).
// Clear literals are inverted by a controlled-NOT (constant 1).
// Literals are ANDed by controlled-swap gates with a constant 0.
// Assumes N_IN >= 2. Garbage order: inverters, then AND gates.
module rpla_and_plane #(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0]                       sel,
    output logic [rpla_pkg::n_term(N_IN)-1:0]     term,
    output logic [rpla_pkg::and_garb(N_IN)-1:0]   garbage
);

    localparam int N_TERM   = rpla_pkg::n_term(N_IN);
    localparam int HALF     = N_TERM / 2;
    localparam int INV_GARB = N_IN * HALF;

    logic [N_IN-1:0][N_TERM-1:0] copies;
    logic [N_TERM-1:0][N_IN-1:0] lit;

    // Copy chains: one private copy of each select bit per minterm.
    for (genvar k = 0; k < N_IN; k++) begin : g_in
        logic [N_TERM-2:0] chain;
        for (genvar j = 0; j < N_TERM - 1; j++) begin : g_cp
            logic src;
            if (j == 0) begin : g_first
                assign src = sel[k];
            end else begin : g_next
                assign src = chain[j-1];
            end
            rev_cnot u_copy (
                .a (src),
                .b (1'b0),
                .p (chain[j]),
                .q (copies[k][j])
            );
        end
        assign copies[k][N_TERM-1] = chain[N_TERM-2];
    end

    // Literal selection and AND chain per minterm.
    for (genvar i = 0; i < N_TERM; i++) begin : g_term
        logic [N_IN-1:0] acc;
        for (genvar k = 0; k < N_IN; k++) begin : g_lit
            if (((i >> k) & 1) == 1) begin : g_true
                assign lit[i][k] = copies[k][i];
            end else begin : g_inv
                rev_cnot u_inv (
                    .a (copies[k][i]),
                    .b (1'b1),
                    .p (garbage[k * HALF + rpla_pkg::drop_bit(i, k)]),
                    .q (lit[i][k])
                );
            end
        end
        assign acc[0] = lit[i][0];
        for (genvar k = 1; k < N_IN; k++) begin : g_and
            localparam int BASE = INV_GARB + 2 * (i * (N_IN - 1) + (k - 1));
            rev_cswap u_and (
                .a (acc[k-1]),
                .b (lit[i][k]),
                .c (1'b0),
                .p (garbage[BASE]),
                .q (garbage[BASE + 1]),
                .r (acc[k])
            );
        end
        assign term[i] = acc[N_IN-1];
    end

    // Guard: exactly one minterm is active for any select value.
    always_comb begin
        a_r3_one_minterm: assert ($countones(term) == 1);
    end

endmodule

// File: rtl/rpla_or_plane.sv
// OR plane: gates each minterm by its program bit and ORs the results.
// Gating is a controlled-swap with a constant 0 (AND, output r).
// Merging is a controlled-swap chain with a constant 1 (OR, output q).
// Assumes term is one-hot. Garbage order: gating gates, then OR gates.
module rpla_or_plane #(
    parameter int N_IN = 3
) (
    input  logic [rpla_pkg::n_term(N_IN)-1:0]    term,
    input  logic [rpla_pkg::n_term(N_IN)-1:0]    prog,
    output logic                                 f,
    output logic [rpla_pkg::or_garb(N_IN)-1:0]   garbage
);

    localparam int N_TERM    = rpla_pkg::n_term(N_IN);
    localparam int GATE_GARB = 2 * N_TERM;

    logic [N_TERM-1:0] picked;
    logic [N_TERM-1:0] merged;

    // Gating: picked[i] = prog[i] AND term[i].
    for (genvar i = 0; i < N_TERM; i++) begin : g_gate
        rev_cswap u_gate (
            .a (prog[i]),
            .b (term[i]),
            .c (1'b0),
            .p (garbage[2 * i]),
            .q (garbage[2 * i + 1]),
            .r (picked[i])
        );
    end

    // OR chain: merged[j] = merged[j-1] OR picked[j].
    assign merged[0] = picked[0];
    for (genvar j = 1; j < N_TERM; j++) begin : g_or
        rev_cswap u_or (
            .a (merged[j-1]),
            .b (picked[j]),
            .c (1'b1),
            .p (garbage[GATE_GARB + 2 * (j - 1)]),
            .q (merged[j]),
            .r (garbage[GATE_GARB + 2 * (j - 1) + 1])
        );
    end

    assign f = merged[N_TERM-1];

    // Guard: empty and full programs give constant outputs.
    always_comb begin
        a_r4_empty_program: assert ((prog != '0) || (f == 1'b0));
        a_r4_full_program: assert ((prog != '1) || (f == 1'b1));
    end

endmodule

// File: rtl/rpla_top.sv
// Reversible programmable logic array, single output.
// f = prog[sel]; every gate output not used is exposed on garbage.
// const_used reports the constant inputs tied inside the structure.
// Purely combinational; assumes N_IN >= 2.
module rpla_top #(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0]                        sel,
    input  logic [rpla_pkg::n_term(N_IN)-1:0]      prog,
    output logic                                   f,
    output logic [rpla_pkg::garb_count(N_IN)-1:0]  garbage,
    output logic [15:0]                            const_used
);

    localparam int N_TERM  = rpla_pkg::n_term(N_IN);
    localparam int AND_G   = rpla_pkg::and_garb(N_IN);
    localparam int OR_G    = rpla_pkg::or_garb(N_IN);
    localparam int CONST_N = rpla_pkg::and_const(N_IN) + rpla_pkg::or_const(N_IN);

    logic [N_TERM-1:0] term;
    logic [AND_G-1:0]  and_garbage;
    logic [OR_G-1:0]   or_garbage;

    rpla_and_plane #(.N_IN(N_IN)) u_and_plane (
        .sel     (sel),
        .term    (term),
        .garbage (and_garbage)
    );

    rpla_or_plane #(.N_IN(N_IN)) u_or_plane (
        .term    (term),
        .prog    (prog),
        .f       (f),
        .garbage (or_garbage)
    );

    // Garbage bus: OR plane in the upper bits, AND plane below.
    assign garbage    = {or_garbage, and_garbage};
    // Constant count report.
    assign const_used = 16'(CONST_N);

    // Guard: output equals the program bit chosen by the select value.
    always_comb begin
        a_r3_selects_bit: assert (f == prog[sel]);
    end

endmodule

// File: tb/tb_rpla_top.sv
// Bench for rpla_top: primitive sweeps, directed corners, exhaustive and
// seeded random program/select checks on 3-input and 2-input builds.
module tb_rpla_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 3-input build
    logic [2:0]  sel3  = '0;
    logic [7:0]  prog3 = '0;
    logic        f3;
    logic [rpla_pkg::garb_count(3)-1:0] garb3;
    logic [15:0] cu3;

    // 2-input build
    logic [1:0]  sel2  = '0;
    logic [3:0]  prog2 = '0;
    logic        f2;
    logic [rpla_pkg::garb_count(2)-1:0] garb2;
    logic [15:0] cu2;

    // Primitives
    logic ca = 1'b0, cb = 1'b0, cp, cq;
    logic sa = 1'b0, sb = 1'b0, sc = 1'b0, sp, sq, sr;

    rpla_top #(.N_IN(3)) dut (
        .sel(sel3), .prog(prog3), .f(f3), .garbage(garb3), .const_used(cu3)
    );
    rpla_top #(.N_IN(2)) dut2 (
        .sel(sel2), .prog(prog2), .f(f2), .garbage(garb2), .const_used(cu2)
    );
    rev_cnot  u_cnot  (.a(ca), .b(cb), .p(cp), .q(cq));
    rev_cswap u_cswap (.a(sa), .b(sb), .c(sc), .p(sp), .q(sq), .r(sr));

    // Counted comparison with a FAIL line on mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected function output from the requirement: bit sel of prog.
    function automatic int exp_f(input int prog, input int sel);
        return (prog >> sel) & 1;
    endfunction

    // Expected controlled-swap outputs {p,q,r}.
    function automatic int exp_swap(input int a, input int b, input int c);
        int q = a ? c : b;
        int r = a ? b : c;
        return (a << 2) | (q << 1) | r;
    endfunction

    task automatic drive3(input int prog, input int sel, input string req);
        @(posedge clk);
        prog3 = prog[7:0];
        sel3  = sel[2:0];
        @(negedge clk);
        chk(req, int'(f3), exp_f(prog, sel));
    endtask

    task automatic drive2(input int prog, input int sel, input string req);
        @(posedge clk);
        prog2 = prog[3:0];
        sel2  = sel[1:0];
        @(negedge clk);
        chk(req, int'(f2), exp_f(prog, sel));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        int seen;
        void'($urandom(32'd2011));

        // Initial state: empty program, select 0 gives 0 (R4)
        @(negedge clk);
        chk("R4 initial", int'(f3), 0);

        // R1: controlled-NOT mapping and bijection
        seen = 0;
        for (int v = 0; v < 4; v++) begin
            @(posedge clk);
            ca = v[1];
            cb = v[0];
            @(negedge clk);
            chk("R1 p", int'(cp), v >> 1);
            chk("R1 q", int'(cq), (v >> 1) ^ (v & 1));
            seen |= 1 << {cp, cq};
        end
        chk("R1 bijection", seen, 4'hF);

        // R2: controlled-swap mapping, ones kept, bijection
        seen = 0;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk);
            sa = v[2];
            sb = v[1];
            sc = v[0];
            @(negedge clk);
            chk("R2 map", int'({sp, sq, sr}), exp_swap(v >> 2, (v >> 1) & 1, v & 1));
            chk("R2 ones", $countones({sp, sq, sr}), $countones(v[2:0]));
            seen |= 1 << {sp, sq, sr};
        end
        chk("R2 bijection", seen, 8'hFF);

        // R5: garbage bus widths
        chk("R5 width 3-in", $bits(garb3), 74);
        chk("R5 width 2-in", $bits(garb2), 26);

        // R6: constant counts and input/output balance
        chk("R6 const 3-in", int'(cu3), 64);
        chk("R6 const 2-in", int'(cu2), 21);
        chk("R6 balance 3-in", int'(cu3) + 3 + 8, $bits(garb3) + 1);
        chk("R6 balance 2-in", int'(cu2) + 2 + 4, $bits(garb2) + 1);

        // R4: empty and full programs
        for (int s = 0; s < 8; s++) drive3(8'h00, s, "R4 empty 3-in");
        for (int s = 0; s < 8; s++) drive3(8'hFF, s, "R4 full 3-in");
        for (int s = 0; s < 4; s++) drive2(4'h0, s, "R4 empty 2-in");
        for (int s = 0; s < 4; s++) drive2(4'hF, s, "R4 full 2-in");

        // R3: single-hot programs pick exactly one select value
        for (int b = 0; b < 8; b++)
            for (int s = 0; s < 8; s++) drive3(1 << b, s, "R3 one-hot");

        // R3: exhaustive programs on both builds
        for (int p = 0; p < 256; p++)
            for (int s = 0; s < 8; s++) drive3(p, s, "R3 sweep 3-in");
        for (int p = 0; p < 16; p++)
            for (int s = 0; s < 4; s++) drive2(p, s, "R3 sweep 2-in");

        // R3: seeded random pairs
        for (int n = 0; n < 300; n++) begin
            int p = int'($urandom_range(255));
            int s = int'($urandom_range(7));
            drive3(p, s, "R3 random 3-in");
        end

        finish_run();
    end

endmodule